// File: doc/BRIEF.md
# Four-Mode Timer with Variable-Width PWM

This block is a 16-bit timer split into a low and a high byte that can be arranged in four ways, selected by a two-bit mode input. Mode 0 runs the two bytes as independent 8-bit interval timers. Mode 1 keeps the low byte as an 8-bit interval timer and turns the high byte into an 8-bit PWM. Mode 2 chains both bytes into one 16-bit interval timer. Mode 3 uses the chained counter as a PWM whose period is a power of two from 2^9 to 2^16 counts.

Counting is paced by two strobes supplied by the surrounding chip: `tick_i` at the instruction-cycle rate and `tick2_i` at twice that rate. In the two 16-bit modes a resolution bit picks the faster strobe. Each byte raises its own one-cycle overflow request. All control and data pins are plain levels; there is no data stream and no handshake, so no back-pressure applies. Period, compare and mode values are expected to be held by a register file outside this block.

Top module: `mtmr_top`

## Requirements
- R1: In mode 0 (`mode_i`=0) each byte counts from 0 on every `tick_i` strobe taken while `run_i` is high; when the low (high) byte equals `prd_lo_i` (`prd_hi_i`) on a strobe it returns to 0 and `ovf_lo_o` (`ovf_hi_o`) pulses, giving a period of period value + 1 strobes per byte.
- R2: In mode 1 the low byte behaves as in R1; the high byte counts 0..`prd_hi_i` (pulsing `ovf_hi_o` on reload) and `pwm_o` is high while the high byte is below the low 8 bits of the active compare value.
- R3: An active compare value of 0 keeps `pwm_o` low for the whole period in modes 1 and 3.
- R4: An active compare value equal to or above the period length (`prd_hi_i`+1 in mode 1, 2^(9+`vwidth_i`) in mode 3) keeps `pwm_o` high for the whole period.
- R5: In mode 2 the 16-bit count {high,low} returns to 0 when it equals {`prd_hi_i`,`prd_lo_i`} on a strobe, pulsing `ovf_hi_o`; `ovf_lo_o` pulses after every strobe taken while the low byte is 0xFF.
- R6: In mode 3 the count wraps after 2^(9+`vwidth_i`) strobes, pulsing `ovf_hi_o` at the wrap; `ovf_lo_o` follows the rule of R5 and `pwm_o` is high while the count is below the 16-bit active compare value.
- R7: In modes 2 and 3, `half_res_i`=1 selects `tick2_i` as the strobe and 0 selects `tick_i`; in modes 0 and 1 `half_res_i` has no effect.
- R8: A new `cmp_i` becomes the active compare value only at the end of a PWM period (or at any time while `run_i` is low), so the period in progress keeps the old duty.
- R9: While `run_i` is low both bytes are held at 0, both overflow outputs stay low and `pwm_o` is low, whatever the strobes do.
- R10: During reset all outputs are low.
- R11: Each overflow pulse lasts one cycle and appears in the cycle right after the clock edge that took the reloading strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable; low holds the counter cleared |
| mode_i | input | 2 | Arrangement: 0 dual timer, 1 timer+PWM, 2 16-bit timer, 3 variable PWM |
| half_res_i | input | 1 | Modes 2/3: count on `tick2_i` instead of `tick_i` |
| vwidth_i | input | 3 | Mode 3 period width minus 9 (0 = 9 bits ... 7 = 16 bits) |
| tick_i | input | 1 | Strobe at instruction-cycle rate |
| tick2_i | input | 1 | Strobe at twice the instruction-cycle rate |
| prd_lo_i | input | 8 | Low byte period (match) value |
| prd_hi_i | input | 8 | High byte period (match) value |
| cmp_i | input | 16 | PWM compare value (mode 1 uses bits 7:0) |
| pwm_o | output | 1 | PWM output |
| ovf_lo_o | output | 1 | Low byte overflow request, one-cycle pulse |
| ovf_hi_o | output | 1 | High byte overflow request, one-cycle pulse |

## Verification
Every count and overflow pulse is due one cycle after the edge that takes the strobe, and `pwm_o` follows the count combinationally in that same cycle, so all outputs are sampled on the falling edge that follows each rising edge. Rather than pinning individual edges, each stimulus row is run for a whole number of output periods starting one edge after `run_i` rises, and the bench compares how many sampled cycles carried each overflow pulse and a high PWM level; that tally is independent of strobe phase. The compare-update case waits for an `ovf_hi_o` pulse, changes `cmp_i` in that cycle and expects the old duty for exactly one further period and the new duty in the period after.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  typedef enum logic [1:0] {
    MD_DUAL    = 2'd0,
    MD_TMR_PWM = 2'd1,
    MD_WIDE    = 2'd2,
    MD_VPWM    = 2'd3
  } mtmr_mode_e;

endpackage

// File: rtl/mtmr_tick_sel.sv
module mtmr_tick_sel
  import mtmr_pkg::*;
(
  input  mtmr_mode_e mode_i,
  input  logic       run_i,
  input  logic       half_res_i,
  input  logic       tick_i,
  input  logic       tick2_i,
  output logic       adv_lo_o,
  output logic       adv_hi_o
);

  logic wide_mode;
  logic wide_strobe;

  assign wide_mode   = (mode_i == MD_WIDE) || (mode_i == MD_VPWM);
  assign wide_strobe = half_res_i ? tick2_i : tick_i;

  // Byte modes always use the base strobe; chained modes honour the resolution bit.
  assign adv_lo_o = run_i && (wide_mode ? wide_strobe : tick_i);
  assign adv_hi_o = run_i && (wide_mode ? wide_strobe : tick_i);

endmodule

// File: rtl/mtmr_count.sv
module mtmr_count
  import mtmr_pkg::*;
#(
  parameter int HW  = 8,
  parameter int WSW = $clog2(HW),
  parameter int FW  = 2 * HW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  mtmr_mode_e     mode_i,
  input  logic [WSW-1:0] vwidth_i,
  input  logic           adv_lo_i,
  input  logic           adv_hi_i,
  input  logic [HW-1:0]  prd_lo_i,
  input  logic [HW-1:0]  prd_hi_i,
  output logic [FW-1:0]  cnt_o,
  output logic           pend_o,
  output logic           ovf_lo_o,
  output logic           ovf_hi_o
);

  localparam logic [FW-1:0] ONE     = FW'(1);
  localparam logic [HW-1:0] LO_ONES = {HW{1'b1}};

  logic [HW-1:0] lo_q, hi_q, lo_n, hi_n;
  logic [FW-1:0] full, full_n, vmask, prd_full;
  logic          fl_lo, fl_hi, ovf_lo_q, ovf_hi_q;

  assign full     = {hi_q, lo_q};
  assign prd_full = {prd_hi_i, prd_lo_i};
  assign vmask    = (ONE << (HW + 1 + int'(vwidth_i))) - ONE;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    full_n = full;
    fl_lo  = 1'b0;
    fl_hi  = 1'b0;
    pend_o = 1'b0;
    unique case (mode_i)
      MD_DUAL, MD_TMR_PWM: begin
        if (adv_lo_i) begin
          if (lo_q == prd_lo_i) begin
            lo_n  = '0;
            fl_lo = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
        if (adv_hi_i) begin
          if (hi_q == prd_hi_i) begin
            hi_n   = '0;
            fl_hi  = 1'b1;
            pend_o = (mode_i == MD_TMR_PWM);
          end else begin
            hi_n = hi_q + 1'b1;
          end
        end
      end
      MD_WIDE: begin
        if (adv_hi_i) begin
          fl_lo = (lo_q == LO_ONES);
          if (full == prd_full) begin
            full_n = '0;
            fl_hi  = 1'b1;
          end else begin
            full_n = full + ONE;
          end
        end
        {hi_n, lo_n} = full_n;
      end
      default: begin
        if (adv_hi_i) begin
          fl_lo = (lo_q == LO_ONES);
          if ((full & vmask) == vmask) begin
            full_n = '0;
            fl_hi  = 1'b1;
            pend_o = 1'b1;
          end else begin
            full_n = (full + ONE) & vmask;
          end
        end
        {hi_n, lo_n} = full_n;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else if (!run_i) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ovf_lo_q <= 1'b0;
      ovf_hi_q <= 1'b0;
    end else begin
      lo_q     <= lo_n;
      hi_q     <= hi_n;
      ovf_lo_q <= fl_lo;
      ovf_hi_q <= fl_hi;
    end
  end

  assign cnt_o    = full;
  assign ovf_lo_o = ovf_lo_q;
  assign ovf_hi_o = ovf_hi_q;

  // R11: a low overflow pulse is always caused by a strobe on the previous edge
  p_lo_flag_from_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_lo_q |-> $past(adv_lo_i));

  // R11: same for the high byte
  p_hi_flag_from_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_hi_q |-> $past(adv_hi_i));

  // R9: a stopped timer leaves a cleared count and no requests
  p_stop_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0) && !ovf_lo_q && !ovf_hi_q);

endmodule

// File: rtl/mtmr_pwm.sv
module mtmr_pwm
  import mtmr_pkg::*;
#(
  parameter int HW  = 8,
  parameter int WSW = $clog2(HW),
  parameter int FW  = 2 * HW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  mtmr_mode_e     mode_i,
  input  logic [WSW-1:0] vwidth_i,
  input  logic [FW-1:0]  cnt_i,
  input  logic           pend_i,
  input  logic [FW-1:0]  cmp_i,
  output logic           pwm_o
);

  localparam logic [FW-1:0] ONE = FW'(1);

  logic [FW-1:0] cmp_q;
  logic [FW-1:0] vmask;
  logic          lvl_byte, lvl_wide;

  assign vmask = (ONE << (HW + 1 + int'(vwidth_i))) - ONE;

  // Shadowed compare: follows the input while idle, otherwise only at a period end.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cmp_q <= '0;
    else if (!run_i || pend_i)  cmp_q <= cmp_i;
  end

  assign lvl_byte = cnt_i[FW-1:HW] < cmp_q[HW-1:0];
  assign lvl_wide = cnt_i < cmp_q;

  always_comb begin
    pwm_o = 1'b0;
    if (run_i) begin
      if (mode_i == MD_TMR_PWM)   pwm_o = lvl_byte;
      else if (mode_i == MD_VPWM) pwm_o = lvl_wide;
    end
  end

  // R8: the active compare value never moves mid-period while running
  p_cmp_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pend_i) |=> $stable(cmp_q));

  // R3: zero compare never drives the output high
  p_zero_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == '0) |-> !pwm_o);

  // R4: a compare beyond the variable period keeps the output high
  p_over_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == MD_VPWM && cmp_q > vmask) |-> pwm_o);

  // R9: output low while stopped
  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_o);

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
  import mtmr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic [1:0]  mode_i,
  input  logic        half_res_i,
  input  logic [2:0]  vwidth_i,
  input  logic        tick_i,
  input  logic        tick2_i,
  input  logic [7:0]  prd_lo_i,
  input  logic [7:0]  prd_hi_i,
  input  logic [15:0] cmp_i,
  output logic        pwm_o,
  output logic        ovf_lo_o,
  output logic        ovf_hi_o
);

  localparam int HW  = 8;
  localparam int WSW = $clog2(HW);
  localparam int FW  = 2 * HW;

  mtmr_mode_e    mode;
  logic          adv_lo, adv_hi, pend;
  logic [FW-1:0] cnt;

  assign mode = mtmr_mode_e'(mode_i);

  mtmr_tick_sel u_tick (
    .mode_i     (mode),
    .run_i      (run_i),
    .half_res_i (half_res_i),
    .tick_i     (tick_i),
    .tick2_i    (tick2_i),
    .adv_lo_o   (adv_lo),
    .adv_hi_o   (adv_hi)
  );

  mtmr_count #(.HW(HW), .WSW(WSW), .FW(FW)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .mode_i   (mode),
    .vwidth_i (vwidth_i),
    .adv_lo_i (adv_lo),
    .adv_hi_i (adv_hi),
    .prd_lo_i (prd_lo_i),
    .prd_hi_i (prd_hi_i),
    .cnt_o    (cnt),
    .pend_o   (pend),
    .ovf_lo_o (ovf_lo_o),
    .ovf_hi_o (ovf_hi_o)
  );

  mtmr_pwm #(.HW(HW), .WSW(WSW), .FW(FW)) u_pwm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .mode_i   (mode),
    .vwidth_i (vwidth_i),
    .cnt_i    (cnt),
    .pend_i   (pend),
    .cmp_i    (cmp_i),
    .pwm_o    (pwm_o)
  );

  // R10: outputs quiet in the first cycle after reset release
  p_reset_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !ovf_lo_o && !ovf_hi_o);

endmodule

// File: tb/mtmr_top_tb.sv
module mtmr_top_tb;

  typedef struct packed {
    logic [1:0]  mode;
    logic        res;
    logic [2:0]  wsel;
    logic [7:0]  plo;
    logic [7:0]  phi;
    logic [15:0] cmp;
    logic [15:0] len;
    logic [7:0]  elo;
    logic [7:0]  ehi;
    logic [15:0] epwm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd0, 1'b0, 3'd0, 8'd3, 8'd4, 16'd0,    16'd80,   8'd10, 8'd8, 16'd0},
    '{2'd1, 1'b0, 3'd0, 8'd9, 8'd7, 16'd3,    16'd80,   8'd4,  8'd5, 16'd30},
    '{2'd1, 1'b0, 3'd0, 8'd9, 8'd7, 16'd0,    16'd80,   8'd4,  8'd5, 16'd0},
    '{2'd1, 1'b0, 3'd0, 8'd9, 8'd7, 16'd8,    16'd80,   8'd4,  8'd5, 16'd80},
    '{2'd2, 1'b0, 3'd0, 8'd9, 8'd0, 16'd0,    16'd80,   8'd0,  8'd4, 16'd0},
    '{2'd2, 1'b1, 3'd0, 8'd3, 8'd1, 16'd0,    16'd520,  8'd2,  8'd2, 16'd0},
    '{2'd3, 1'b1, 3'd0, 8'd0, 8'd0, 16'd100,  16'd1024, 8'd4,  8'd2, 16'd200},
    '{2'd3, 1'b0, 3'd1, 8'd0, 8'd0, 16'd2000, 16'd2048, 8'd4,  8'd1, 16'd2048},
    '{2'd3, 1'b1, 3'd0, 8'd0, 8'd0, 16'd0,    16'd512,  8'd2,  8'd1, 16'd0},
    '{2'd0, 1'b1, 3'd0, 8'd3, 8'd4, 16'd0,    16'd80,   8'd10, 8'd8, 16'd0}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1 mode0";
      1: return "R2 mode1 duty";
      2: return "R3 mode1 zero";
      3: return "R4 mode1 full";
      4: return "R5 mode2";
      5: return "R7 mode2 half-res";
      6: return "R6 mode3 9-bit";
      7: return "R4 mode3 over";
      8: return "R3 mode3 zero";
      default: return "R7 mode0 res ignored";
    endcase
  endfunction

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        half_res_i = 1'b0;
  logic [2:0]  vwidth_i = '0;
  logic        tick_i = 1'b0;
  logic        tick2_i = 1'b1;
  logic [7:0]  prd_lo_i = '0;
  logic [7:0]  prd_hi_i = '0;
  logic [15:0] cmp_i = '0;
  logic        pwm_o, ovf_lo_o, ovf_hi_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;
  always @(negedge clk_i) tick_i <= ~tick_i;

  mtmr_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .mode_i(mode_i),
    .half_res_i(half_res_i), .vwidth_i(vwidth_i), .tick_i(tick_i),
    .tick2_i(tick2_i), .prd_lo_i(prd_lo_i), .prd_hi_i(prd_hi_i),
    .cmp_i(cmp_i), .pwm_o(pwm_o), .ovf_lo_o(ovf_lo_o), .ovf_hi_o(ovf_hi_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Sample len cycles at falling edges, tallying each output.
  task automatic tally(input int len, output int clo, output int chi, output int cpw);
    clo = 0; chi = 0; cpw = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk_i);
      clo += int'(ovf_lo_o);
      chi += int'(ovf_hi_o);
      cpw += int'(pwm_o);
    end
  endtask

  task automatic start(input vec_t v);
    @(negedge clk_i);
    run_i = 1'b0;
    repeat (2) @(negedge clk_i);
    mode_i = v.mode; half_res_i = v.res; vwidth_i = v.wsel;
    prd_lo_i = v.plo; prd_hi_i = v.phi; cmp_i = v.cmp;
    @(negedge clk_i);
    run_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    summary();
  end

  initial begin
    int clo, chi, cpw, prev, adj;
    vec_t dv;

    // R10: outputs during reset
    repeat (3) @(negedge clk_i);
    chk("R10 reset pwm", int'(pwm_o), 0);
    chk("R10 reset ovf_lo", int'(ovf_lo_o), 0);
    chk("R10 reset ovf_hi", int'(ovf_hi_o), 0);
    rst_ni = 1'b1;

    // Vector table: whole-period tallies
    for (int i = 0; i < NV; i++) begin
      start(VT[i]);
      tally(int'(VT[i].len), clo, chi, cpw);
      chk({vtag(i), " ovf_lo"}, clo, int'(VT[i].elo));
      chk({vtag(i), " ovf_hi"}, chi, int'(VT[i].ehi));
      chk({vtag(i), " pwm"},    cpw, int'(VT[i].epwm));
    end

    // R9: stopped timer ignores strobes
    dv = '{2'd1, 1'b0, 3'd0, 8'd0, 8'd0, 16'd255, 16'd0, 8'd0, 8'd0, 16'd0};
    start(dv);
    run_i = 1'b0;
    tally(40, clo, chi, cpw);
    chk("R9 stopped ovf_lo", clo, 0);
    chk("R9 stopped ovf_hi", chi, 0);
    chk("R9 stopped pwm", cpw, 0);

    // R11: reload every strobe -> single-cycle pulses, never back to back
    dv = '{2'd0, 1'b0, 3'd0, 8'd0, 8'd7, 16'd0, 16'd0, 8'd0, 8'd0, 16'd0};
    start(dv);
    @(negedge clk_i);
    prev = 0; adj = 0; clo = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (prev == 1 && ovf_lo_o) adj++;
      prev = int'(ovf_lo_o);
      clo += int'(ovf_lo_o);
    end
    chk("R11 pulse count", clo, 10);
    chk("R11 back-to-back pulses", adj, 0);

    // R8: compare change mid-run applies from the next period
    dv = '{2'd1, 1'b0, 3'd0, 8'd9, 8'd7, 16'd3, 16'd0, 8'd0, 8'd0, 16'd0};
    start(dv);
    @(negedge clk_i);
    while (!ovf_hi_o) @(negedge clk_i);
    cmp_i = 16'd6;
    cpw = int'(pwm_o);
    for (int k = 1; k < 16; k++) begin
      @(negedge clk_i);
      cpw += int'(pwm_o);
    end
    chk("R8 old duty kept", cpw, 6);
    tally(16, clo, chi, cpw);
    chk("R8 new duty applied", cpw, 12);
    chk("R8 boundary pulse", chi, 1);

    run_i = 1'b0;
    @(negedge clk_i);
    summary();
  end

endmodule